// File: doc/BRIEF.md
# Debug-Boot Reset Vector Controller

This block sits between a debug test-access port and the reset and fetch logic of an embedded processor. The port can issue an "arm debug boot" command that sets a sticky internal flag. The flag survives any processor-only reset and is cleared only by a "disarm" command or by power-on reset. While the processor is held in reset, three control bits are loaded from that flag, all together. The break bit requests a debug exception. The trap bit selects the probe-served debug vector. The probe-enable bit makes fetches from the debug segment wait for the probe.

Once the processor leaves reset, the block presents the first fetch address. This is the probe-served debug vector when the trap bit is set and a configurable normal vector otherwise. The block also raises a debug exception request, which it holds until the core takes it. When probe service is enabled, a core fetch into the debug segment is parked. The block shows a pending flag and the parked address to the probe, and it releases the core only when the probe acknowledges with a 32-bit instruction word. The tap shift chain, the pipeline and the memory system are modelled as plain request, acknowledge and data ports.

Top module: `dbg_boot_vec_ctrl`

## Requirements
- R1: Power-on reset (`por_n` low) clears the boot flag and all three control bits. After power-on reset with no command, `reset_vector` equals `NORM_VEC` (default 0xBFC0_0000) and `dbg_req` is 0.
- R2: A valid tap command with code 2'b01 (arm) sets `boot_armed` at the next clock edge. The flag keeps its value through any processor reset (`cpu_rst_n` low with `por_n` high).
- R3: A valid tap command with code 2'b10 (disarm) clears `boot_armed`. Codes 2'b00 and 2'b11, and any code with `tap_cmd_valid` low, leave the flag unchanged.
- R4: On every clock edge while `cpu_rst_n` is low, `ctl_brk`, `ctl_trap` and `ctl_probe_en` all load the value of `boot_armed`: all three become 1 or all three become 0. Outside reset, trap and probe-enable do not change.
- R5: `dbg_req` is 0 while the processor is in reset. From the first cycle after reset release, it equals the break bit. The break bit stays set until a cycle with `dbg_ack` high, after which both the break bit and `dbg_req` are 0.
- R6: `reset_vector` is `DBG_VEC` (default 0xFF20_0200) when the trap bit is set, and `NORM_VEC` otherwise.
- R7: With probe-enable set, a core request whose address falls in the debug segment [0xFF20_0000, 0xFF40_0000) sets `probe_pending` and `core_stall` one cycle later, and `probe_addr` shows the request address.
- R8: A probe acknowledge while an access is pending clears the pending flag. In the next cycle it gives a single-cycle `core_rvalid` with `core_rdata` equal to the acknowledged `probe_instr`. An acknowledge with nothing pending produces no `core_rvalid`.
- R9: A core request outside the debug segment, or any request while probe-enable is clear, never sets `probe_pending`.
- R10: While an access is pending, further core requests are ignored: `probe_addr` keeps the first address until the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears the boot flag |
| cpu_rst_n | input | 1 | Processor reset, active low, synchronous; loads control bits from the flag |
| tap_cmd_valid | input | 1 | Tap command strobe |
| tap_cmd | input | 2 | Tap command code: 01 arm, 10 disarm, others no operation |
| boot_armed | output | 1 | Current boot-into-debug flag |
| ctl_brk | output | 1 | Break-request control bit |
| ctl_trap | output | 1 | Probe-vector select control bit |
| ctl_probe_en | output | 1 | Probe-service enable control bit |
| reset_vector | output | ADDR_W | First fetch address after reset |
| dbg_req | output | 1 | Debug exception request to the core |
| dbg_ack | input | 1 | Core has taken the debug exception |
| core_req | input | 1 | Core fetch request |
| core_addr | input | ADDR_W | Core fetch address |
| core_stall | output | 1 | Core must wait for a probe-served word |
| core_rvalid | output | 1 | Probe-served word is valid |
| core_rdata | output | DATA_W | Probe-served instruction word |
| probe_pending | output | 1 | Processor access awaiting the probe |
| probe_addr | output | ADDR_W | Address of the pending access |
| probe_ack | input | 1 | Probe completes the pending access |
| probe_instr | input | DATA_W | Instruction word supplied by the probe |

## Verification
The assertions check, on every cycle, that the flag moves only on arm or disarm, that the three bits load as one value during reset and that trap and probe-enable stay fixed afterwards. They also check that the break bit holds until acknowledged, that a pending access keeps its address until the probe answers, that pending never starts without probe-enable, and that each acknowledge gives exactly one response beat. Only the bench scenarios can show the values involved. These are the flag surviving a processor reset, the chosen vector for each boot mode, the instruction word reaching the core, rejection of out-of-segment and non-probe requests, and power-on reset overriding an armed flag.

// File: rtl/dbgboot_pkg.sv
`timescale 1ns/1ps
package dbgboot_pkg;

   // Tap command codes; the numeric values are decoded by the flag holder.
   typedef enum logic [1:0] {
      TAP_NOP    = 2'b00,
      TAP_ARM    = 2'b01,
      TAP_DISARM = 2'b10,
      TAP_RSVD   = 2'b11
   } tap_cmd_e;

   // The three debug control bits loaded at reset.
   typedef struct packed {
      logic brk;
      logic trap;
      logic pen;
   } ctl_bits_t;

   localparam ctl_bits_t CTL_CLEAR = '{brk: 1'b0, trap: 1'b0, pen: 1'b0};

   function automatic ctl_bits_t ctl_fill(input logic v);
      ctl_bits_t r;
      r.brk  = v;
      r.trap = v;
      r.pen  = v;
      return r;
   endfunction

endpackage

// File: rtl/dbgboot_flag.sv
`timescale 1ns/1ps
module dbgboot_flag
   import dbgboot_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       cmd_valid,
   input  logic [1:0] cmd,
   output logic       armed
);

   logic do_arm;
   logic do_disarm;

   assign do_arm    = cmd_valid && (cmd == TAP_ARM);
   assign do_disarm = cmd_valid && (cmd == TAP_DISARM);

   // Sticky flag: only power-on reset or an explicit command moves it.
   always_ff @(posedge clk) begin
      if (!por_n) begin
         armed <= 1'b0;
      end else if (do_arm) begin
         armed <= 1'b1;
      end else if (do_disarm) begin
         armed <= 1'b0;
      end
   end

   AST_FLAG_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!por_n)
      (!(cmd_valid && (cmd == TAP_ARM || cmd == TAP_DISARM))) |=> $stable(armed)); // R3

   AST_ARM_SETS_FLAG: assert property (@(posedge clk) disable iff (!por_n)
      (cmd_valid && cmd == TAP_ARM) |=> armed); // R2

   AST_DISARM_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!por_n)
      (cmd_valid && cmd == TAP_DISARM) |=> !armed); // R3

endmodule

// File: rtl/dbgboot_ctl.sv
`timescale 1ns/1ps
module dbgboot_ctl
   import dbgboot_pkg::*;
#(
   parameter int unsigned     ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] NORM_VEC = 32'hBFC0_0000,
   parameter logic [ADDR_W-1:0] DBG_VEC  = 32'hFF20_0200,
   parameter bit              REG_VEC  = 1'b0
)(
   input  logic              clk,
   input  logic              por_n,
   input  logic              cpu_rst_n,
   input  logic              armed,
   input  logic              brk_ack,
   output ctl_bits_t         bits,
   output logic              run,
   output logic              dbg_req,
   output logic [ADDR_W-1:0] reset_vec
);

   logic [ADDR_W-1:0] vec_sel;

   assign run = por_n && cpu_rst_n;

   // Reset values follow the flag: the bits load synchronously on every
   // reset cycle instead of using an asynchronous non-constant reset value.
   always_ff @(posedge clk) begin
      if (!por_n) begin
         bits <= CTL_CLEAR;
      end else if (!cpu_rst_n) begin
         bits <= ctl_fill(armed);
      end else if (brk_ack && bits.brk) begin
         bits.brk <= 1'b0;
      end
   end

   assign dbg_req = run && bits.brk;
   assign vec_sel = bits.trap ? DBG_VEC : NORM_VEC;

   generate
      if (REG_VEC) begin : g_vec_reg
         logic [ADDR_W-1:0] vec_q;
         always_ff @(posedge clk) begin
            vec_q <= vec_sel;
         end
         assign reset_vec = vec_q;
      end else begin : g_vec_comb
         assign reset_vec = vec_sel;
      end
   endgenerate

   AST_BITS_UNIFORM: assert property (@(posedge clk) disable iff (!por_n)
      (!cpu_rst_n) |=> (bits.brk == bits.trap && bits.trap == bits.pen)); // R4

   AST_BITS_FOLLOW_FLAG: assert property (@(posedge clk) disable iff (!por_n)
      (!cpu_rst_n) |=> (bits.pen == $past(armed))); // R4

   AST_TRAP_PEN_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
      cpu_rst_n |=> $stable({bits.trap, bits.pen})); // R4

   AST_BRK_HELD: assert property (@(posedge clk) disable iff (!por_n)
      (cpu_rst_n && bits.brk && !brk_ack) |=> bits.brk); // R5

   AST_NO_REQ_IN_RESET: assert property (@(posedge clk)
      (!cpu_rst_n) |-> !dbg_req); // R5

endmodule

// File: rtl/dbgboot_probe.sv
`timescale 1ns/1ps
module dbgboot_probe #(
   parameter int unsigned       ADDR_W    = 32,
   parameter int unsigned       DATA_W    = 32,
   parameter logic [ADDR_W-1:0] SEG_BASE  = 32'hFF20_0000,
   parameter logic [ADDR_W-1:0] SEG_BYTES = 32'h0020_0000,
   parameter bit                REG_RESP  = 1'b1
)(
   input  logic              clk,
   input  logic              run,
   input  logic              probe_en,
   input  logic              core_req,
   input  logic [ADDR_W-1:0] core_addr,
   input  logic              probe_ack,
   input  logic [DATA_W-1:0] probe_data,
   output logic              pend,
   output logic [ADDR_W-1:0] pend_addr,
   output logic              rvalid,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [ADDR_W-1:0] SEG_MASK = ~(SEG_BYTES - 1'b1);
   localparam bit SEG_POW2 = ((SEG_BYTES & (SEG_BYTES - 1'b1)) == '0)
                             && ((SEG_BASE & ~SEG_MASK) == '0);
   localparam logic [ADDR_W:0] SEG_END = {1'b0, SEG_BASE} + {1'b0, SEG_BYTES};

   logic in_seg;
   logic claim;
   logic finish;

   // Segment decode: mask compare when the window is aligned, else range.
   generate
      if (SEG_POW2) begin : g_dec_mask
         assign in_seg = ((core_addr & SEG_MASK) == SEG_BASE);
      end else begin : g_dec_range
         assign in_seg = (core_addr >= SEG_BASE) && ({1'b0, core_addr} < SEG_END);
      end
   endgenerate

   assign claim  = run && core_req && probe_en && in_seg && !pend;
   assign finish = pend && probe_ack;

   always_ff @(posedge clk) begin
      if (!run) begin
         pend      <= 1'b0;
         pend_addr <= '0;
      end else if (claim) begin
         pend      <= 1'b1;
         pend_addr <= core_addr;
      end else if (finish) begin
         pend      <= 1'b0;
      end
   end

   generate
      if (REG_RESP) begin : g_resp_reg
         always_ff @(posedge clk) begin
            if (!run) begin
               rvalid <= 1'b0;
               rdata  <= '0;
            end else begin
               rvalid <= finish;
               if (finish) begin
                  rdata <= probe_data;
               end
            end
         end

         AST_ACK_GIVES_BEAT: assert property (@(posedge clk) disable iff (!run)
            finish |=> rvalid); // R8

         AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!run)
            rvalid |=> !rvalid); // R8
      end else begin : g_resp_comb
         assign rvalid = finish;
         assign rdata  = probe_data;
      end
   endgenerate

   AST_PEND_HELD: assert property (@(posedge clk) disable iff (!run)
      (pend && !probe_ack) |=> (pend && $stable(pend_addr))); // R10

   AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!run)
      $rose(pend) |-> $past(probe_en)); // R9

   AST_ACK_CLEARS_PEND: assert property (@(posedge clk) disable iff (!run)
      finish |=> !pend); // R8

endmodule

// File: rtl/dbg_boot_vec_ctrl.sv
`timescale 1ns/1ps
module dbg_boot_vec_ctrl
   import dbgboot_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 32,
   parameter int unsigned       DATA_W    = 32,
   parameter logic [ADDR_W-1:0] NORM_VEC  = 32'hBFC0_0000,
   parameter logic [ADDR_W-1:0] DBG_VEC   = 32'hFF20_0200,
   parameter logic [ADDR_W-1:0] SEG_BASE  = 32'hFF20_0000,
   parameter logic [ADDR_W-1:0] SEG_BYTES = 32'h0020_0000,
   parameter bit                REG_VEC   = 1'b0,
   parameter bit                REG_RESP  = 1'b1
)(
   input  logic              clk,
   input  logic              por_n,
   input  logic              cpu_rst_n,
   input  logic              tap_cmd_valid,
   input  logic [1:0]        tap_cmd,
   output logic              boot_armed,
   output logic              ctl_brk,
   output logic              ctl_trap,
   output logic              ctl_probe_en,
   output logic [ADDR_W-1:0] reset_vector,
   output logic              dbg_req,
   input  logic              dbg_ack,
   input  logic              core_req,
   input  logic [ADDR_W-1:0] core_addr,
   output logic              core_stall,
   output logic              core_rvalid,
   output logic [DATA_W-1:0] core_rdata,
   output logic              probe_pending,
   output logic [ADDR_W-1:0] probe_addr,
   input  logic              probe_ack,
   input  logic [DATA_W-1:0] probe_instr
);

   localparam logic [ADDR_W:0] SEG_LIMIT = {1'b0, SEG_BASE} + {1'b0, SEG_BYTES};

   // Elaboration-time parameter checks.
   generate
      if (ADDR_W < 16 || ADDR_W > 64) begin : g_bad_addr_w
         $error("ADDR_W must lie between 16 and 64");
      end
      if (DATA_W < 16) begin : g_bad_data_w
         $error("DATA_W must be at least 16");
      end
      if (SEG_BYTES == '0) begin : g_bad_seg
         $error("SEG_BYTES must be non-zero");
      end
      if (DBG_VEC[1:0] != 2'b00 || NORM_VEC[1:0] != 2'b00) begin : g_bad_align
         $error("reset vectors must be word aligned");
      end
      if (DBG_VEC < SEG_BASE || {1'b0, DBG_VEC} >= SEG_LIMIT) begin : g_bad_dbg_vec
         $error("DBG_VEC must fall inside the debug segment");
      end
   endgenerate

   ctl_bits_t bits;
   logic      run;

   dbgboot_flag u_flag (
      .clk       (clk),
      .por_n     (por_n),
      .cmd_valid (tap_cmd_valid),
      .cmd       (tap_cmd),
      .armed     (boot_armed)
   );

   dbgboot_ctl #(
      .ADDR_W   (ADDR_W),
      .NORM_VEC (NORM_VEC),
      .DBG_VEC  (DBG_VEC),
      .REG_VEC  (REG_VEC)
   ) u_ctl (
      .clk       (clk),
      .por_n     (por_n),
      .cpu_rst_n (cpu_rst_n),
      .armed     (boot_armed),
      .brk_ack   (dbg_ack),
      .bits      (bits),
      .run       (run),
      .dbg_req   (dbg_req),
      .reset_vec (reset_vector)
   );

   dbgboot_probe #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .SEG_BASE  (SEG_BASE),
      .SEG_BYTES (SEG_BYTES),
      .REG_RESP  (REG_RESP)
   ) u_probe (
      .clk        (clk),
      .run        (run),
      .probe_en   (bits.pen),
      .core_req   (core_req),
      .core_addr  (core_addr),
      .probe_ack  (probe_ack),
      .probe_data (probe_instr),
      .pend       (probe_pending),
      .pend_addr  (probe_addr),
      .rvalid     (core_rvalid),
      .rdata      (core_rdata)
   );

   assign ctl_brk      = bits.brk;
   assign ctl_trap     = bits.trap;
   assign ctl_probe_en = bits.pen;
   assign core_stall   = probe_pending;

   AST_POR_CLEARS_ALL: assert property (@(posedge clk)
      (!por_n) |=> (!boot_armed && !ctl_brk && !ctl_trap && !ctl_probe_en)); // R1

   AST_STALL_ONLY_WITH_PEN: assert property (@(posedge clk) disable iff (!run)
      core_stall |-> ctl_probe_en); // R9

endmodule

// File: tb/dbg_boot_vec_ctrl_bench.sv
`timescale 1ns/1ps
module dbg_boot_vec_ctrl_bench;

   localparam logic [31:0] NORM = 32'hBFC0_0000;
   localparam logic [31:0] DVEC = 32'hFF20_0200;

   logic        clk = 1'b0;
   logic        por_n, cpu_rst_n, tap_cmd_valid, dbg_ack, core_req, probe_ack;
   logic [1:0]  tap_cmd;
   logic [31:0] core_addr, probe_instr;
   logic        boot_armed, ctl_brk, ctl_trap, ctl_probe_en, dbg_req;
   logic        core_stall, core_rvalid, probe_pending;
   logic [31:0] reset_vector, core_rdata, probe_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   dbg_boot_vec_ctrl u_dbg_boot_vec_ctrl (
      .clk(clk), .por_n(por_n), .cpu_rst_n(cpu_rst_n),
      .tap_cmd_valid(tap_cmd_valid), .tap_cmd(tap_cmd),
      .boot_armed(boot_armed), .ctl_brk(ctl_brk), .ctl_trap(ctl_trap),
      .ctl_probe_en(ctl_probe_en), .reset_vector(reset_vector),
      .dbg_req(dbg_req), .dbg_ack(dbg_ack),
      .core_req(core_req), .core_addr(core_addr), .core_stall(core_stall),
      .core_rvalid(core_rvalid), .core_rdata(core_rdata),
      .probe_pending(probe_pending), .probe_addr(probe_addr),
      .probe_ack(probe_ack), .probe_instr(probe_instr)
   );

   // Table entry: {cmd_valid, cmd[1:0], expected flag afterwards}
   localparam logic [3:0] TBL [7] = '{
      4'b1_01_1,   // arm
      4'b1_00_1,   // nop code: no effect
      4'b1_11_1,   // reserved code: no effect
      4'b0_10_1,   // disarm without strobe: no effect
      4'b1_10_0,   // disarm
      4'b1_00_0,   // nop code: no effect
      4'b1_01_1    // arm again
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic send_cmd(input logic v, input logic [1:0] c);
      tap_cmd_valid = v;
      tap_cmd       = c;
      tick();
      tap_cmd_valid = 1'b0;
      tap_cmd       = 2'b00;
   endtask

   task automatic cpu_reset();
      cpu_rst_n = 1'b0;
      tick();
      tick();
      check("R5 no request in reset", {31'd0, dbg_req}, 32'd0);
      cpu_rst_n = 1'b1;
      #1;
   endtask

   task automatic core_fetch(input logic [31:0] a);
      core_req  = 1'b1;
      core_addr = a;
      tick();
      core_req  = 1'b0;
   endtask

   initial begin
      por_n = 1'b0; cpu_rst_n = 1'b0; tap_cmd_valid = 1'b0; tap_cmd = 2'b00;
      dbg_ack = 1'b0; core_req = 1'b0; core_addr = '0; probe_ack = 1'b0;
      probe_instr = '0;
      @(negedge clk);
      tick(); tick();
      // R1: reset state
      check("R1 flag after por", {31'd0, boot_armed}, 32'd0);
      check("R1 bits after por", {29'd0, ctl_brk, ctl_trap, ctl_probe_en}, 32'd0);
      por_n = 1'b1;
      tick();
      cpu_rst_n = 1'b1;
      tick();
      check("R1 normal vector", reset_vector, NORM);
      check("R1 no debug request", {31'd0, dbg_req}, 32'd0);

      // Table walk: command, processor reset, resulting bits and vector
      for (int i = 0; i < 7; i++) begin
         logic e;
         e = TBL[i][0];
         send_cmd(TBL[i][3], TBL[i][2:1]);
         check("R2 R3 flag after command", {31'd0, boot_armed}, {31'd0, e});
         cpu_reset();
         check("R5 request in first run cycle", {31'd0, dbg_req}, {31'd0, e});
         @(negedge clk);
         check("R2 flag kept through cpu reset", {31'd0, boot_armed}, {31'd0, e});
         check("R4 bits loaded", {29'd0, ctl_brk, ctl_trap, ctl_probe_en}, {29'd0, {3{e}}});
         check("R6 first fetch vector", reset_vector, e ? DVEC : NORM);
         check("R5 request held", {31'd0, dbg_req}, {31'd0, e});
         if (e) begin
            dbg_ack = 1'b1;
            tick();
            dbg_ack = 1'b0;
            check("R5 request cleared by ack", {30'd0, dbg_req, ctl_brk}, 32'd0);
            check("R4 trap kept after ack", {30'd0, ctl_trap, ctl_probe_en}, 32'd3);
         end
      end

      // R7: probe-served access into the debug segment
      core_fetch(32'hFF20_0200);
      check("R7 pending", {30'd0, probe_pending, core_stall}, 32'd3);
      check("R7 pending address", probe_addr, 32'hFF20_0200);
      // R10: second request while pending is ignored
      core_fetch(32'hFF20_0004);
      check("R10 address kept", probe_addr, 32'hFF20_0200);
      tick(); tick();
      check("R7 still waiting", {31'd0, core_stall}, 32'd1);
      check("R8 no beat before ack", {31'd0, core_rvalid}, 32'd0);
      // R8: acknowledge with instruction word
      probe_instr = 32'h1234_5678;
      probe_ack   = 1'b1;
      tick();
      probe_ack   = 1'b0;
      check("R8 beat valid", {31'd0, core_rvalid}, 32'd1);
      check("R8 beat data", core_rdata, 32'h1234_5678);
      check("R8 pending cleared", {31'd0, probe_pending}, 32'd0);
      tick();
      check("R8 single beat", {31'd0, core_rvalid}, 32'd0);
      // R8: stray acknowledge
      probe_ack = 1'b1;
      tick();
      probe_ack = 1'b0;
      tick();
      check("R8 stray ack ignored", {30'd0, core_rvalid, probe_pending}, 32'd0);
      // R9: outside the segment
      core_fetch(32'h8000_0000);
      check("R9 outside segment", {31'd0, probe_pending}, 32'd0);
      core_fetch(32'hFF40_0000);
      check("R9 just past segment", {31'd0, probe_pending}, 32'd0);
      // R7: last word of segment is inside
      core_fetch(32'hFF3F_FFFC);
      check("R7 segment top", {31'd0, probe_pending}, 32'd1);
      probe_instr = 32'hCAFE_0001;
      probe_ack = 1'b1;
      tick();
      probe_ack = 1'b0;
      check("R8 second beat data", core_rdata, 32'hCAFE_0001);

      // R9: probe enable clear
      send_cmd(1'b1, 2'b10);
      cpu_reset();
      tick();
      check("R9 probe enable clear", {31'd0, ctl_probe_en}, 32'd0);
      core_fetch(32'hFF20_0200);
      check("R9 no pending without enable", {30'd0, probe_pending, core_stall}, 32'd0);

      // R1: power-on reset overrides an armed flag
      send_cmd(1'b1, 2'b01);
      check("R2 armed", {31'd0, boot_armed}, 32'd1);
      por_n = 1'b0;
      tick();
      por_n = 1'b1;
      check("R1 por clears armed flag", {31'd0, boot_armed}, 32'd0);
      cpu_reset();
      tick();
      check("R1 bits clear after por", {29'd0, ctl_brk, ctl_trap, ctl_probe_en}, 32'd0);
      check("R6 normal vector after por", reset_vector, NORM);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule